// File: doc/BRIEF.md
# Video Vertical Sync Generator

This block produces the vertical sync pulse for a video output path. All of its timing is counted in half-lines of the output horizontal timing: a one-clock strobe `hl_tick`, supplied from outside in the output clock domain, marks each half-line boundary. The block never makes its own horizontal timing. It only counts strobes, so every edge of the output pulse falls on one of them.

The 2-bit `mode` input selects one of three ways of placing the pulse.
- **Input-reset mode (code 0).** Each rising edge of an incoming vertical sync starts a delay, and one pulse follows each field. The block measures the spacing of those edges in half-lines and holds back the pulse when the delay would run past the next edge.
- **Trigger-reset mode (code 1).** The reference is the rising edge of an external frame trigger, and one pulse follows each frame. The pulse is held back when the delay is one frame length or more.
- **Divide mode (codes 2 and 3).** The block counts frames on its own, each `frame_len` half-lines long. It starts a pulse at each frame start and puts out a one-clock trigger that a second device in trigger-reset mode can lock to.

Both asynchronous inputs, `vsync_in` and `trig_in`, are synchronized into the clock domain before their edges are detected. Every pin is a plain control or status level: no data streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `vsync_timing_gen`

## Requirements
- R1: With delay setting d (`delay_hl`, 11 bits), a pulse that is not suppressed asserts on the (d+1)-th `hl_tick` strobe after its reference event. The output changes level only in the clock after a strobe.
- R2: In mode code 0, the reference event is a rising edge of `vsync_in`, and each accepted edge yields one pulse.
- R3: In mode code 1, the reference event is a rising edge of `trig_in`. The pulse is suppressed when d >= `frame_len`.
- R4: In mode codes 2 and 3, a frame starts every `frame_len` strobes, and the pulse asserts on the frame-start strobe whatever d holds.
- R5: In mode code 0, the pulse is suppressed when d is greater than or equal to the number of strobes between the two most recent rising edges of `vsync_in`. No pulse follows the first edge after reset.
- R6: The pulse stays active for W strobes, where W is 3 half-lines when `narrow`=1. When `narrow`=0, W is 6 half-lines with `std525`=1 and 5 half-lines with `std525`=0.
- R7: With `pol_low`=0 the pulse is high and the idle level is low. With `pol_low`=1 the pulse is low and the idle level is high.
- R8: `trig_out` is a one-clock high pulse, asserted in the same clock the vertical pulse asserts at each frame start of mode codes 2 and 3. It stays low in modes 0 and 1.
- R9: If a new pulse starts on the strobe where the current pulse would end, the output stays active with no gap and runs a further W strobes.
- R10: During and right after reset, the output sits at its idle level and `trig_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Active-low reset |
| hl_tick | input | 1 | One-clock half-line strobe |
| vsync_in | input | 1 | Asynchronous input vertical sync |
| trig_in | input | 1 | Asynchronous frame trigger from another device |
| mode | input | 2 | 0 input-reset, 1 trigger-reset, 2/3 divide |
| delay_hl | input | 11 | Delay in half-lines |
| frame_len | input | 12 | Frame length in half-lines (modes 1 to 3) |
| pol_low | input | 1 | 1 selects an active-low pulse |
| narrow | input | 1 | 1 selects the 1.5-line width |
| std525 | input | 1 | 1 selects 525-line widths, 0 selects 625-line widths |
| vs_out | output | 1 | Vertical sync pulse |
| trig_out | output | 1 | Frame-start trigger in divide mode |

## Verification
The start of a new pulse and the end of the current one can land on the same strobe. To provoke this, trigger-reset mode is run with a zero delay and the narrow width, and a second trigger edge is placed so that its pulse starts exactly on the strobe where the first pulse ends. The bench judges the result from the run of consecutive active strobe samples, which must reach twice the width with no idle sample between the two pulses.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef enum logic [1:0] {
    VSG_MODE_INPUT = 2'd0,
    VSG_MODE_TRIG  = 2'd1,
    VSG_MODE_DIV   = 2'd2,
    VSG_MODE_DIV2  = 2'd3
  } vsg_mode_e;

  localparam int unsigned WIDTH_W   = 3;
  localparam int unsigned HL_NARROW = 3;  // 1.5 lines
  localparam int unsigned HL_525    = 6;  // 3 lines
  localparam int unsigned HL_625    = 5;  // 2.5 lines

  function automatic logic [WIDTH_W-1:0] width_hl(input logic narrow,
                                                  input logic std525);
    if (narrow)      return WIDTH_W'(HL_NARROW);
    else if (std525) return WIDTH_W'(HL_525);
    else             return WIDTH_W'(HL_625);
  endfunction

endpackage

// File: rtl/vsg_sync_edge.sv
module vsg_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  // One-clock pulse on a synchronized rising edge
  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/vsg_period_meter.sv
module vsg_period_meter #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned DELAY_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               ev,
  input  logic [DELAY_W-1:0] delay,
  output logic               allow
);
  localparam int unsigned CMP_W = ((CNT_W > DELAY_W) ? CNT_W : DELAY_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             seen;
  logic [CMP_W-1:0] d_ext, p_ext;

  assign d_ext = CMP_W'(delay);
  assign p_ext = CMP_W'(cnt);
  // The period just ending is compared at the edge that closes it
  assign allow = seen && (d_ext < p_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (ev) begin
      cnt  <= '0;
      seen <= 1'b1;
    end else if (tick && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vsg_delay_timer.sv
module vsg_delay_timer #(
  parameter int unsigned DELAY_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               ev,
  input  logic               arm_ok,
  input  logic [DELAY_W-1:0] delay,
  output logic               start
);
  logic               armed;
  logic [DELAY_W-1:0] cnt;

  // A new reference event takes priority over a strobe in the same clock
  assign start = armed & tick & ~ev & (cnt == delay);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (ev) begin
      armed <= arm_ok;
      cnt   <= '0;
    end else if (start) begin
      armed <= 1'b0;
    end else if (armed && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vsg_frame_div.sv
module vsg_frame_div #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame_len,
  output logic               start
);
  logic [FRAME_W-1:0] fc;

  assign start = en & tick & (fc == frame_len - FRAME_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fc <= '0;
    else if (!en)      fc <= '0;
    else if (start)    fc <= '0;
    else if (tick)     fc <= fc + 1'b1;
  end
endmodule

// File: rtl/vsg_pulse_shaper.sv
module vsg_pulse_shaper #(
  parameter int unsigned WIDTH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               start,
  input  logic [WIDTH_W-1:0] width,
  output logic               active
);
  logic [WIDTH_W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem    <= '0;
    end else if (start) begin
      // A start on the final strobe reloads the width with no gap
      active <= 1'b1;
      rem    <= width;
    end else if (active && tick) begin
      if (rem <= WIDTH_W'(1)) active <= 1'b0;
      else                    rem    <= rem - 1'b1;
    end
  end
endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vsg_pkg::*;
#(
  parameter int unsigned DELAY_W     = 11,
  parameter int unsigned FRAME_W     = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hl_tick,
  input  logic               vsync_in,
  input  logic               trig_in,
  input  logic [1:0]         mode,
  input  logic [DELAY_W-1:0] delay_hl,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic               pol_low,
  input  logic               narrow,
  input  logic               std525,
  output logic               vs_out,
  output logic               trig_out
);
  localparam int unsigned CMP_W = ((FRAME_W > DELAY_W) ? FRAME_W : DELAY_W) + 1;

  logic ev_vs, ev_tr;
  logic is_input, is_trig, is_div;
  logic ref_ev, arm_ok, meter_ok, frame_ok;
  logic dly_start, div_start, pulse_start;
  logic vs_act, trig_q;
  logic [CMP_W-1:0] d_ext, f_ext;

  assign is_input = (vsg_mode_e'(mode) == VSG_MODE_INPUT);
  assign is_trig  = (vsg_mode_e'(mode) == VSG_MODE_TRIG);
  assign is_div   = ~is_input & ~is_trig;

  vsg_sync_edge #(.STAGES(SYNC_STAGES)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .rise_o(ev_vs)
  );

  vsg_sync_edge #(.STAGES(SYNC_STAGES)) u_tr_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise_o(ev_tr)
  );

  vsg_period_meter #(.CNT_W(FRAME_W), .DELAY_W(DELAY_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .tick(hl_tick), .ev(ev_vs),
    .delay(delay_hl), .allow(meter_ok)
  );

  assign d_ext    = CMP_W'(delay_hl);
  assign f_ext    = CMP_W'(frame_len);
  assign frame_ok = (d_ext < f_ext);

  always_comb begin
    ref_ev = 1'b0;
    arm_ok = 1'b0;
    if (is_input) begin
      ref_ev = ev_vs;
      arm_ok = meter_ok;
    end else if (is_trig) begin
      ref_ev = ev_tr;
      arm_ok = frame_ok;
    end
  end

  vsg_delay_timer #(.DELAY_W(DELAY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .tick(hl_tick), .ev(ref_ev),
    .arm_ok(arm_ok), .delay(delay_hl), .start(dly_start)
  );

  vsg_frame_div #(.FRAME_W(FRAME_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(is_div), .tick(hl_tick),
    .frame_len(frame_len), .start(div_start)
  );

  assign pulse_start = is_div ? div_start : dly_start;

  vsg_pulse_shaper #(.WIDTH_W(WIDTH_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .tick(hl_tick), .start(pulse_start),
    .width(width_hl(narrow, std525)), .active(vs_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= div_start;
  end

  assign trig_out = trig_q;
  assign vs_out   = vs_act ^ pol_low;
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int unsigned FRAME_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hl_tick,
  input logic               div_mode,
  input logic [FRAME_W-1:0] frame_len,
  input logic               trig_out,
  input logic               vs_act
);
  // R1
  edge_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hl_tick) |-> $stable(vs_act));

  // R8
  trig_only_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(div_mode));

  // R8
  trig_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && frame_len > FRAME_W'(1)) |=> (!trig_out || $changed(frame_len)));

  // R4
  trig_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> vs_act);
endmodule

bind vsync_timing_gen vsg_checker #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .div_mode(mode[1]),
  .frame_len(frame_len), .trig_out(trig_out), .vs_act(vs_act)
);

// File: tb/vsync_timing_gen_tb.sv
module vsync_timing_gen_tb;
  logic        clk = 1'b0, rst_n = 1'b0, hl_tick = 1'b0;
  logic        vsync_in = 1'b0, trig_in = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [10:0] delay_hl = '0;
  logic [11:0] frame_len = 12'd100;
  logic        pol_low = 1'b0, narrow = 1'b0, std525 = 1'b0;
  logic        vs_out, trig_out;

  always #10 clk = ~clk;  // 50 MHz

  vsync_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vsync_in(vsync_in),
    .trig_in(trig_in), .mode(mode), .delay_hl(delay_hl), .frame_len(frame_len),
    .pol_low(pol_low), .narrow(narrow), .std525(std525),
    .vs_out(vs_out), .trig_out(trig_out)
  );

  int  checks = 0, fails = 0;
  int  stb_abs = 0, win_idx = 0, first_on = 0, on_cnt = 0;
  int  run_len = 0, max_run = 0;
  int  trig_cnt = 0, last_trig = 0, gap_bad = 0, rise_bad = 0, exp_gap = 0;
  int  trig_run = 0, trig_max = 0;
  bit  prev_act = 1'b0, done = 1'b0;
  event stb_ev;

  // Strobe every 8 clocks; outputs sampled at the negedge after the strobe edge
  initial begin
    forever begin
      repeat (7) @(negedge clk);
      hl_tick = 1'b1;
      @(negedge clk);
      hl_tick = 1'b0;
      begin
        bit act;
        act = (vs_out != pol_low);
        stb_abs++;
        win_idx++;
        if (act) begin
          if (first_on == 0) first_on = win_idx;
          on_cnt++;
          run_len++;
          if (run_len > max_run) max_run = run_len;
        end else begin
          run_len = 0;
        end
        if (trig_out) begin
          trig_cnt++;
          if (last_trig != 0 && stb_abs - last_trig != exp_gap) gap_bad++;
          last_trig = stb_abs;
          if (!(act && !prev_act)) rise_bad++;
        end
        prev_act = act;
      end
      -> stb_ev;
    end
  end

  always @(negedge clk) begin
    if (trig_out) trig_run++;
    else          trig_run = 0;
    if (trig_run > trig_max) trig_max = trig_run;
  end

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic clear_meas();
    win_idx = 0; first_on = 0; on_cnt = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    vsync_in = 1'b0;
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 idle level in reset", int'(vs_out), int'(pol_low));
    chk("R10 trigger low in reset", int'(trig_out), 0);
    rst_n = 1'b1;
    @(stb_ev);
    chk("R10 idle level after reset", int'(vs_out), int'(pol_low));
    run_len = 0; max_run = 0;
    trig_cnt = 0; last_trig = 0; gap_bad = 0; rise_bad = 0; trig_max = 0;
  endtask

  // Raise the chosen reference at a strobe instant and watch n strobes
  task automatic ref_window(input bit use_trig, input int n);
    clear_meas();
    if (use_trig) trig_in = 1'b1; else vsync_in = 1'b1;
    @(stb_ev);
    trig_in = 1'b0;
    vsync_in = 1'b0;
    repeat (n - 1) @(stb_ev);
  endtask

  task automatic t_input_mode();
    mode = 2'd0; delay_hl = 11'd4; narrow = 1'b0; std525 = 1'b0; pol_low = 1'b0;
    do_reset();
    ref_window(1'b0, 20);
    chk("R5 first edge yields no pulse", on_cnt, 0);
    ref_window(1'b0, 20);
    chk("R1 R2 start strobe d=4", first_on, 5);
    chk("R6 625 width", on_cnt, 5);
    delay_hl = 11'd20;
    ref_window(1'b0, 20);
    chk("R5 delay equal period suppressed", on_cnt, 0);
    delay_hl = 11'd19;
    ref_window(1'b0, 20);
    chk("R5 delay just under period", first_on, 20);
  endtask

  task automatic t_trig_mode();
    mode = 2'd1; frame_len = 12'd30; delay_hl = 11'd10;
    narrow = 1'b0; std525 = 1'b0; pol_low = 1'b0;
    do_reset();
    ref_window(1'b1, 40);
    chk("R3 trigger reference start", first_on, 11);
    chk("R3 trigger pulse width", on_cnt, 5);
    chk("R8 no trigger out in mode 1", trig_cnt, 0);
    delay_hl = 11'd30;
    ref_window(1'b1, 40);
    chk("R3 delay equal frame suppressed", on_cnt, 0);
    delay_hl = 11'd29;
    ref_window(1'b1, 40);
    chk("R3 delay just under frame", first_on, 30);
  endtask

  task automatic t_widths();
    mode = 2'd1; frame_len = 12'd100; delay_hl = 11'd2;
    narrow = 1'b0; std525 = 1'b1; pol_low = 1'b0;
    do_reset();
    ref_window(1'b1, 15);
    chk("R6 525 start", first_on, 3);
    chk("R6 525 width", on_cnt, 6);
    narrow = 1'b1; std525 = 1'b0;
    ref_window(1'b1, 15);
    chk("R6 narrow width", on_cnt, 3);
  endtask

  task automatic t_polarity();
    mode = 2'd1; frame_len = 12'd100; delay_hl = 11'd1;
    narrow = 1'b0; std525 = 1'b0; pol_low = 1'b1;
    do_reset();
    ref_window(1'b1, 10);
    chk("R7 active-low start", first_on, 2);
    chk("R7 active-low width", on_cnt, 5);
    chk("R7 idle high after pulse", int'(vs_out), 1);
    pol_low = 1'b0;
  endtask

  task automatic t_divide();
    mode = 2'd2; frame_len = 12'd12; delay_hl = 11'd5; exp_gap = 12;
    narrow = 1'b0; std525 = 1'b0; pol_low = 1'b0;
    do_reset();
    repeat (40) @(stb_ev);
    chk("R4 frame starts seen", int'(trig_cnt >= 3), 1);
    chk("R4 frame spacing", gap_bad, 0);
    chk("R4 R8 pulse rises with trigger, delay ignored", rise_bad, 0);
    chk("R8 trigger one clock wide", trig_max, 1);
  endtask

  task automatic t_coincide();
    mode = 2'd1; frame_len = 12'd100; delay_hl = 11'd0;
    narrow = 1'b1; std525 = 1'b0; pol_low = 1'b0;
    do_reset();
    ref_window(1'b1, 3);
    ref_window(1'b1, 8);
    chk("R9 back-to-back run", max_run, 6);
    chk("R9 second pulse width", on_cnt, 3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_input_mode();
    t_trig_mode();
    t_widths();
    t_polarity();
    t_divide();
    t_coincide();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule